// File: doc/BRIEF.md
# Reciprocal-Multiply Coefficient Quantizer

This block divides transform coefficients of 8x8 image blocks by the entries of a quantization step table. It does not divide. It multiplies each coefficient magnitude by a stored fixed-point reciprocal, rounds, shifts and restores the sign. This runs in a four-stage pipeline that accepts one coefficient per cycle. Coefficients arrive in raster order inside each block. Each coefficient carries a flag that selects the luma table or the chroma table, and a flag that marks the first coefficient of a block.

The step tables come from the usual baseline luma and chroma base tables, scaled by a quality setting in the range 1 to 100. The block can be built in one of two ways:

- **Runtime variant.** The quality is sampled from an input at frame boundaries. The 128-entry reciprocal store is then rebuilt one entry per cycle, and a busy output is held high while the rebuild runs.
- **Fixed variant.** The quality is an elaboration parameter, and the reciprocals become a constant function of the table address.

Top module: `coef_quantizer`

## Requirements
- R1: For a coefficient c and its step Q, the output is sign(c)*((|c|*R + 32768) >> 16), where R = floor((65536 + floor(Q/2)) / Q) is held in 17 bits. The step is taken from table index chroma*64 + position, with position = row*8 + column in raster order. The output is a two's complement value of the same width as the input.
- R2: Each step is the base value b scaled as floor((b*S + 50) / 100) and then limited to the range 1..255. S is floor(5000/q) when q < 50, and 200 - 2q otherwise. The luma base is the usual baseline luminance table. In the chroma base, the upper-left 4x4 corner is the usual values and every other entry is 99.
- R3: A quality value of 0 is treated as 1. A quality value above 100 is treated as 100.
- R4: out_valid, out_chroma and out_first equal in_valid, in_chroma and in_first from exactly four clock cycles earlier. No output is produced without an input.
- R5: An input with in_first high takes position 0. Each further valid input takes the next position. After position 63 the count wraps back to 0, with or without in_first.
- R6: After reset the runtime variant holds table_busy high for exactly 128 cycles while it builds its tables at quality 95.
- R7: quality_in is sampled only in a cycle where frame_start is high and table_busy is low. Changing quality_in at any other time has no effect on the results.
- R8: A frame_start whose limited quality differs from the active quality starts a rebuild: table_busy is high for exactly 128 cycles, and afterwards the new tables are in use. A frame_start whose limited quality equals the active quality leaves table_busy low.
- R9: The fixed variant never raises table_busy, ignores quality_in and frame_start, and always uses the tables for its parameter quality.
- R10: Every output is within 1 of the exact quotient c/Q rounded half away from zero.
- R11: Cycles with in_valid low do not advance the position count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame boundary pulse; quality is sampled here |
| quality_in | input | 7 | Requested quality (runtime variant) |
| in_valid | input | 1 | Coefficient valid |
| in_coef | input | COEF_W | Signed coefficient |
| in_chroma | input | 1 | 0 selects the luma table, 1 selects the chroma table |
| in_first | input | 1 | First coefficient of a block |
| table_busy | output | 1 | Table rebuild in progress |
| out_valid | output | 1 | Quantized value valid |
| out_coef | output | COEF_W | Signed quantized value |
| out_chroma | output | 1 | Delayed table select |
| out_first | output | 1 | Delayed block start |

## Verification
The hardest conditions to reach from the ports are the extremes of the tables. At quality 100 every step is 1, so a full-scale negative coefficient must pass through unchanged. At quality 0, limited to 1, most steps saturate at 255. A rebuild only begins when a frame pulse arrives with a quality that differs from the active one.

The stimulus covers these cases with directed frame pulses at qualities 0, 127, 49, 50 and 20. It also repeats one quality, to confirm that no rebuild starts, and changes quality_in with no pulse, to confirm the change has no effect. After each rebuild it sends blocks that begin with the signed-range corners and continue with seeded random values, with random gaps in in_valid and blocks that wrap without a start flag.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int RECIP_W = 17;
  localparam int Q_W     = 7;
  localparam int ADDR_W  = 7;
  localparam int POS_W   = 6;
  localparam int FRAC    = RECIP_W - 1;

  localparam logic [7:0] LUMA_BASE [64] = '{
    8'd16, 8'd11, 8'd10, 8'd16, 8'd24, 8'd40, 8'd51, 8'd61,
    8'd12, 8'd12, 8'd14, 8'd19, 8'd26, 8'd58, 8'd60, 8'd55,
    8'd14, 8'd13, 8'd16, 8'd24, 8'd40, 8'd57, 8'd69, 8'd56,
    8'd14, 8'd17, 8'd22, 8'd29, 8'd51, 8'd87, 8'd80, 8'd62,
    8'd18, 8'd22, 8'd37, 8'd56, 8'd68, 8'd109, 8'd103, 8'd77,
    8'd24, 8'd35, 8'd55, 8'd64, 8'd81, 8'd104, 8'd113, 8'd92,
    8'd49, 8'd64, 8'd78, 8'd87, 8'd103, 8'd121, 8'd120, 8'd101,
    8'd72, 8'd92, 8'd95, 8'd98, 8'd112, 8'd100, 8'd103, 8'd99};

  localparam logic [7:0] CHROMA_CORNER [16] = '{
    8'd17, 8'd18, 8'd24, 8'd47,
    8'd18, 8'd21, 8'd26, 8'd66,
    8'd24, 8'd26, 8'd56, 8'd99,
    8'd47, 8'd66, 8'd99, 8'd99};

  // Base step for a table index: bit 6 picks chroma, bits 5:0 are row*8+col.
  function automatic int unsigned base_step(input logic [ADDR_W-1:0] idx);
    if (!idx[6]) return 32'(LUMA_BASE[idx[5:0]]);
    if (!idx[5] && !idx[2]) return 32'(CHROMA_CORNER[{idx[4:3], idx[1:0]}]);
    return 32'd99;
  endfunction

  function automatic logic [Q_W-1:0] clamp_quality(input logic [Q_W-1:0] q);
    if (q == '0) return Q_W'(1);
    if (q > Q_W'(100)) return Q_W'(100);
    return q;
  endfunction

  function automatic int unsigned quality_scale(input logic [Q_W-1:0] q);
    if (q < Q_W'(50)) return 32'd5000 / 32'(q);
    return 32'd200 - 32'd2 * 32'(q);
  endfunction

  function automatic logic [7:0] scaled_step(input logic [ADDR_W-1:0] idx,
                                             input logic [Q_W-1:0] q);
    int unsigned v;
    v = (base_step(idx) * quality_scale(q) + 32'd50) / 32'd100;
    if (v < 32'd1) v = 32'd1;
    if (v > 32'd255) v = 32'd255;
    return 8'(v);
  endfunction

  function automatic logic [RECIP_W-1:0] recip_of(input logic [7:0] step);
    int unsigned s;
    s = 32'(step);
    return RECIP_W'((32'd65536 + s / 32'd2) / s);
  endfunction
endpackage

// File: rtl/cq_position.sv
module cq_position
  import cq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] next_pos;

  assign pos = in_first ? '0 : next_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) next_pos <= '0;
    else if (in_valid) next_pos <= pos + POS_W'(1);
  end
endmodule

// File: rtl/cq_table.sv
module cq_table
  import cq_pkg::*;
#(
  parameter int FIXED_MODE    = 0,
  parameter int FIXED_QUALITY = 95,
  parameter int RESET_QUALITY = 95
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [Q_W-1:0]     quality_in,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [RECIP_W-1:0] rd_recip,
  output logic               busy,
  output logic [Q_W-1:0]     q_live
);
  localparam int ENTRIES = 1 << ADDR_W;
  localparam logic RESET_BUSY = (FIXED_MODE == 0);
  localparam logic [Q_W-1:0] INIT_Q =
    (FIXED_MODE != 0) ? clamp_quality(Q_W'(FIXED_QUALITY)) : clamp_quality(Q_W'(RESET_QUALITY));

  logic [ADDR_W-1:0] wr_idx;
  logic [Q_W-1:0]    q_req;
  logic              start_rebuild;

  assign q_req         = clamp_quality(quality_in);
  assign start_rebuild = RESET_BUSY && frame_start && !busy && (q_req != q_live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= RESET_BUSY;
      wr_idx <= '0;
      q_live <= INIT_Q;
    end else if (start_rebuild) begin
      busy   <= 1'b1;
      wr_idx <= '0;
      q_live <= q_req;
    end else if (busy) begin
      wr_idx <= wr_idx + ADDR_W'(1);
      if (wr_idx == ADDR_W'(ENTRIES - 1)) busy <= 1'b0;
    end
  end

  generate
    if (FIXED_MODE != 0) begin : g_const
      assign rd_recip = recip_of(scaled_step(rd_addr, INIT_Q));
    end else begin : g_store
      logic [RECIP_W-1:0] store [ENTRIES];
      always_ff @(posedge clk) begin
        if (busy) store[wr_idx] <= recip_of(scaled_step(wr_idx, q_live));
      end
      assign rd_recip = store[rd_addr];
    end
  endgenerate
endmodule

// File: rtl/cq_pipe.sv
module cq_pipe
  import cq_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COEF_W-1:0]  in_coef,
  input  logic               in_chroma,
  input  logic               in_first,
  input  logic [POS_W-1:0]   in_pos,
  output logic [ADDR_W-1:0]  tbl_addr,
  input  logic [RECIP_W-1:0] tbl_recip,
  output logic               out_valid,
  output logic [COEF_W-1:0]  out_coef,
  output logic               out_chroma,
  output logic               out_first
);
  localparam int PROD_W = COEF_W + RECIP_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC - 1);

  function automatic logic [COEF_W-1:0] magnitude(input logic [COEF_W-1:0] c);
    return c[COEF_W-1] ? (~c + COEF_W'(1)) : c;
  endfunction

  function automatic logic [COEF_W-1:0] round_shift(input logic [PROD_W-1:0] p);
    logic [PROD_W-1:0] t;
    t = (p + HALF) >> FRAC;
    return COEF_W'(t);
  endfunction

  // stage 1: capture and position
  logic              v1, ch1, f1;
  logic [COEF_W-1:0] c1;
  logic [POS_W-1:0]  p1;
  // stage 2: magnitude and reciprocal
  logic              v2, ch2, f2, s2;
  logic [COEF_W-1:0] m2;
  logic [RECIP_W-1:0] r2;
  // stage 3: product
  logic              v3, ch3, f3, s3;
  logic [PROD_W-1:0] prod3;

  assign tbl_addr = {ch1, p1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; ch1 <= 1'b0; f1 <= 1'b0; c1 <= '0; p1 <= '0;
      v2 <= 1'b0; ch2 <= 1'b0; f2 <= 1'b0; s2 <= 1'b0; m2 <= '0; r2 <= '0;
      v3 <= 1'b0; ch3 <= 1'b0; f3 <= 1'b0; s3 <= 1'b0; prod3 <= '0;
      out_valid <= 1'b0; out_chroma <= 1'b0; out_first <= 1'b0; out_coef <= '0;
    end else begin
      v1 <= in_valid; ch1 <= in_chroma; f1 <= in_first; c1 <= in_coef; p1 <= in_pos;
      v2 <= v1; ch2 <= ch1; f2 <= f1;
      s2 <= c1[COEF_W-1];
      m2 <= magnitude(c1);
      r2 <= tbl_recip;
      v3 <= v2; ch3 <= ch2; f3 <= f2; s3 <= s2;
      prod3 <= {{RECIP_W{1'b0}}, m2} * {{COEF_W{1'b0}}, r2};
      out_valid  <= v3;
      out_chroma <= ch3;
      out_first  <= f3;
      out_coef   <= s3 ? (~round_shift(prod3) + COEF_W'(1)) : round_shift(prod3);
    end
  end
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import cq_pkg::*;
#(
  parameter int COEF_W        = 12,
  parameter int FIXED_MODE    = 0,
  parameter int FIXED_QUALITY = 95,
  parameter int RESET_QUALITY = 95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [6:0]        quality_in,
  input  logic              in_valid,
  input  logic [COEF_W-1:0] in_coef,
  input  logic              in_chroma,
  input  logic              in_first,
  output logic              table_busy,
  output logic              out_valid,
  output logic [COEF_W-1:0] out_coef,
  output logic              out_chroma,
  output logic              out_first
);
  logic [POS_W-1:0]   cur_pos;
  logic [ADDR_W-1:0]  rd_addr;
  logic [RECIP_W-1:0] rd_recip;
  logic [Q_W-1:0]     q_live;

  cq_position u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .pos(cur_pos)
  );

  cq_table #(
    .FIXED_MODE(FIXED_MODE), .FIXED_QUALITY(FIXED_QUALITY), .RESET_QUALITY(RESET_QUALITY)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .quality_in(quality_in),
    .rd_addr(rd_addr), .rd_recip(rd_recip), .busy(table_busy), .q_live(q_live)
  );

  cq_pipe #(.COEF_W(COEF_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .in_chroma(in_chroma), .in_first(in_first), .in_pos(cur_pos),
    .tbl_addr(rd_addr), .tbl_recip(rd_recip),
    .out_valid(out_valid), .out_coef(out_coef), .out_chroma(out_chroma), .out_first(out_first)
  );
endmodule

// File: rtl/coef_quantizer_chk.sv
module coef_quantizer_chk #(
  parameter int COEF_W     = 12,
  parameter int FIXED_MODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              in_valid,
  input logic [COEF_W-1:0] in_coef,
  input logic              in_chroma,
  input logic              in_first,
  input logic              table_busy,
  input logic              out_valid,
  input logic [COEF_W-1:0] out_coef,
  input logic              out_chroma,
  input logic              out_first,
  input logic [6:0]        q_live
);
  logic [2:0] since_rst;
  logic [8:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (table_busy) busy_len <= busy_len + 9'd1;
    else busy_len <= '0;
  end

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_tag_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && out_valid) |->
      (out_chroma == $past(in_chroma, 4) && out_first == $past(in_first, 4)));

  assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && out_valid && out_coef != '0) |->
      (out_coef[COEF_W-1] == $past(in_coef[COEF_W-1], 4)));

  assert_zero_in_zero_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && out_valid && $past(in_coef, 4) == '0) |-> (out_coef == '0));

  assert_rebuild_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(table_busy) |-> (busy_len == 9'd128));

  assert_rebuild_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(table_busy) |-> $past(frame_start));

  assert_quality_moves_with_rebuild_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_live) |-> $rose(table_busy));

  assert_quality_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_live >= 7'd1 && q_live <= 7'd100));

  generate
    if (FIXED_MODE != 0) begin : g_fixed
      assert_fixed_never_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !table_busy);
    end
  endgenerate
endmodule

bind coef_quantizer coef_quantizer_chk #(.COEF_W(COEF_W), .FIXED_MODE(FIXED_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_coef(in_coef), .in_chroma(in_chroma), .in_first(in_first),
  .table_busy(table_busy), .out_valid(out_valid), .out_coef(out_coef),
  .out_chroma(out_chroma), .out_first(out_first), .q_live(q_live)
);

// File: tb/coef_quantizer_test.sv
module coef_quantizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int FX_Q = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [6:0] quality_in = 7'd95;
  logic in_valid = 1'b0;
  logic [CW-1:0] in_coef = '0;
  logic in_chroma = 1'b0;
  logic in_first = 1'b0;
  logic table_busy, out_valid, out_chroma, out_first;
  logic [CW-1:0] out_coef;
  logic fx_busy, fx_valid, fx_chroma, fx_first;
  logic [CW-1:0] fx_coef;

  always #(CLK_PERIOD / 2) clk = ~clk;

  coef_quantizer uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .quality_in(quality_in),
    .in_valid(in_valid), .in_coef(in_coef), .in_chroma(in_chroma), .in_first(in_first),
    .table_busy(table_busy), .out_valid(out_valid), .out_coef(out_coef),
    .out_chroma(out_chroma), .out_first(out_first));

  coef_quantizer #(.FIXED_MODE(1), .FIXED_QUALITY(FX_Q)) uut_fx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .quality_in(quality_in),
    .in_valid(in_valid), .in_coef(in_coef), .in_chroma(in_chroma), .in_first(in_first),
    .table_busy(fx_busy), .out_valid(fx_valid), .out_coef(fx_coef),
    .out_chroma(fx_chroma), .out_first(fx_first));

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int mq = 95;
  int mpos = 0;
  bit finished = 0;

  int e_coef [16];
  int e_idx [16];
  int e_q [16];
  int e_stamp [16];
  bit e_first [16];
  int head = 0;
  int tail = 0;

  int luma_ref [64] = '{16,11,10,16,24,40,51,61, 12,12,14,19,26,58,60,55,
                        14,13,16,24,40,57,69,56, 14,17,22,29,51,87,80,62,
                        18,22,37,56,68,109,103,77, 24,35,55,64,81,104,113,92,
                        49,64,78,87,103,121,120,101, 72,92,95,98,112,100,103,99};
  int chroma_top [16] = '{17,18,24,47, 18,21,26,66, 24,26,56,99, 47,66,99,99};

  // R3: quality limiting
  function automatic int lim_q(int q);
    if (q < 1) return 1;
    if (q > 100) return 100;
    return q;
  endfunction

  // R2: scaled step
  function automatic int step_of(int idx, int q);
    int b, s, v, r, c;
    r = (idx % 64) / 8;
    c = idx % 8;
    if (idx < 64) b = luma_ref[idx];
    else if (r < 4 && c < 4) b = chroma_top[r * 4 + c];
    else b = 99;
    s = (q < 50) ? (5000 / q) : (200 - 2 * q);
    v = (b * s + 50) / 100;
    if (v < 1) v = 1;
    if (v > 255) v = 255;
    return v;
  endfunction

  // R1: reciprocal quantization
  function automatic int quant_ref(int c, int idx, int q);
    longint m, rc, qs, res;
    qs = longint'(step_of(idx, lim_q(q)));
    rc = (65536 + qs / 2) / qs;
    m = (c < 0) ? -longint'(c) : longint'(c);
    res = (m * rc + 32768) >>> 16;
    return (c < 0) ? -int'(res) : int'(res);
  endfunction

  // R10: exact rounded quotient
  function automatic int exact_ref(int c, int idx, int q);
    int qs, m, res;
    qs = step_of(idx, lim_q(q));
    m = (c < 0) ? -c : c;
    res = (2 * m + qs) / (2 * qs);
    return (c < 0) ? -res : res;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv, string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc = cyc + 1;

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (head != tail && e_stamp[head % 16] == cyc) begin
        int k, a, x, ex;
        k = head % 16;
        chk(out_valid == 1'b1, "R4", int'(out_valid), 1, "valid four cycles later");
        a = int'($signed(out_coef));
        x = quant_ref(e_coef[k], e_idx[k], e_q[k]);
        chk(a == x, "R1", a, x, "quantized value");
        ex = exact_ref(e_coef[k], e_idx[k], e_q[k]);
        chk((a - ex) <= 1 && (ex - a) <= 1, "R10", a, ex, "distance from exact quotient");
        chk(out_chroma == (e_idx[k] >= 64), "R4", int'(out_chroma), int'(e_idx[k] >= 64), "chroma tag");
        chk(out_first == e_first[k], "R4", int'(out_first), int'(e_first[k]), "first tag");
        a = int'($signed(fx_coef));
        x = quant_ref(e_coef[k], e_idx[k], FX_Q);
        chk(fx_valid && a == x, "R9", a, x, "fixed variant value");
        head++;
      end else begin
        if (out_valid) chk(1'b0, "R4", 1, 0, "unexpected output");
        if (fx_valid) chk(1'b0, "R9", 1, 0, "unexpected fixed output");
      end
    end
  end

  task automatic put(int c, bit ch, bit f);
    @(negedge clk);
    in_valid = 1'b1;
    in_coef = CW'(c);
    in_chroma = ch;
    in_first = f;
    if (f) mpos = 0;
    e_coef[tail % 16] = c;
    e_idx[tail % 16] = (ch ? 64 : 0) + mpos;
    e_q[tail % 16] = mq;
    e_first[tail % 16] = f;
    e_stamp[tail % 16] = cyc + 4;
    tail++;
    mpos = (mpos + 1) % 64;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
    end
  endtask

  function automatic int rnd_coef();
    return int'($urandom_range(4095, 0)) - 2048;
  endfunction

  // block starting with the signed-range corners, optional gaps (R11)
  task automatic send_block(bit ch, bit first, bit gaps);
    int c;
    for (int i = 0; i < 64; i++) begin
      case (i)
        0: c = 0;
        1: c = 1;
        2: c = -1;
        3: c = 2047;
        4: c = -2048;
        5: c = 8;
        6: c = -8;
        default: c = rnd_coef();
      endcase
      if (gaps && i > 0 && ($urandom_range(4, 0) == 0)) idle(int'($urandom_range(3, 1)));
      put(c, ch, first && (i == 0));
    end
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (table_busy && n < 1000) begin
      n++;
      chk(fx_busy == 1'b0, "R9", int'(fx_busy), 0, "fixed variant busy");
      @(negedge clk);
    end
  endtask

  task automatic new_quality(int q, bit expect_rebuild);
    int n;
    @(negedge clk);
    frame_start = 1'b1;
    quality_in = 7'(q);
    @(negedge clk);
    frame_start = 1'b0;
    if (expect_rebuild) begin
      wait_busy(n);
      chk(n == 128, "R8", n, 128, "rebuild length");
      mq = lim_q(q);
    end else begin
      chk(table_busy == 1'b0, "R8", int'(table_busy), 0, "no rebuild for same quality");
      @(negedge clk);
      chk(table_busy == 1'b0, "R8", int'(table_busy), 0, "still idle");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(table_busy == 1'b1, "R6", int'(table_busy), 1, "busy after reset");
    chk(out_valid == 1'b0, "R4", int'(out_valid), 0, "no output in reset");
    chk(fx_busy == 1'b0, "R9", int'(fx_busy), 0, "fixed idle after reset");
    wait_busy(n);
    chk(n == 128, "R6", n, 128, "initial build length");

    // default quality, both tables
    send_block(1'b0, 1'b1, 1'b0);
    send_block(1'b1, 1'b1, 1'b0);
    idle(6);

    // random blocks with gaps (R11) and wrap without a start flag (R5)
    for (int b = 0; b < 6; b++) send_block(1'($urandom_range(1, 0)), 1'b1, 1'b1);
    send_block(1'b0, 1'b0, 1'b1);
    // restart in the middle of a block (R5)
    for (int i = 0; i < 10; i++) put(rnd_coef(), 1'b1, i == 0);
    send_block(1'b1, 1'b1, 1'b0);
    idle(6);

    // quality change with no frame pulse has no effect (R7)
    quality_in = 7'd20;
    send_block(1'b0, 1'b1, 1'b0);
    idle(6);

    new_quality(20, 1'b1);
    send_block(1'b0, 1'b1, 1'b0);
    send_block(1'b1, 1'b1, 1'b1);
    idle(6);
    new_quality(20, 1'b0);
    new_quality(0, 1'b1);
    send_block(1'b0, 1'b1, 1'b0);
    send_block(1'b1, 1'b1, 1'b0);
    idle(6);
    new_quality(127, 1'b1);
    send_block(1'b0, 1'b1, 1'b0);
    send_block(1'b1, 1'b1, 1'b0);
    idle(6);
    new_quality(100, 1'b0);
    new_quality(49, 1'b1);
    send_block(1'b0, 1'b1, 1'b1);
    send_block(1'b1, 1'b1, 1'b0);
    idle(6);
    new_quality(50, 1'b1);
    send_block(1'b0, 1'b1, 1'b0);
    send_block(1'b1, 1'b1, 1'b1);
    idle(8);
    chk(head == tail, "R4", head, tail, "all inputs produced outputs");
    summary();
  end
endmodule